// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, and moves data between them in either direction. The path is cut into independent lane groups. With the default parameters there are two 8-bit groups, so the block works as two byte-wide transceivers or, with the controls tied together, as one 16-bit transceiver. Each group has its own controls:

- an active-low drive enable;
- a direction bit;
- one capture strobe for each direction;
- one select for each direction, choosing between the stored word and the live word.

Each direction of each group has a holding register. The register samples its source bus when its capture strobe rises. The strobe rise is detected against the block clock. The select then puts either the live source word or the stored word on the far output.

Three-state pins are modelled as a data output plus a per-bit enable vector. An enable vector of all zeros means the bus is undriven. When a group's drive enable is deasserted, both sides of that group are released. The registers still capture while the outputs are released, so a word can be parked in one register, or in both, and sent later.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low at a clock edge, every holding register is cleared to zero. Because of this, a select of 1 presents 0 on the data outputs after reset.
- R2: When `cap_ab[g]` is sampled high at a clock edge and was sampled low at the previous edge, that group's slice of `a_in` is stored in its A-to-B register. The stored value is visible from the next cycle.
- R3: When `cap_ba[g]` rises in the same sense as in R2, that group's slice of `b_in` is stored in its B-to-A register.
- R4: With `sel_ab[g]`=0, the group's slice of `b_out` equals the live `a_in` slice; with `sel_ab[g]`=1 it equals the stored A-to-B word. `sel_ba[g]` selects in the same way for `a_out`, using `b_in` and the B-to-A word. The data outputs carry this value whatever the enables are.
- R5: With `oe_n[g]`=0 and `dir[g]`=1, the group's slice of `b_oe` is all ones and its slice of `a_oe` is all zeros. With `oe_n[g]`=0 and `dir[g]`=0, `a_oe` is all ones and `b_oe` is all zeros.
- R6: With `oe_n[g]`=1, both enable slices of the group are all zeros, and the registers of the group still capture as in R2 and R3.
- R7: The A and B enable slices of one group are never both nonzero.
- R8: The controls of one group have no effect on the registers or outputs of any other group.
- R9: A register changes only on a detected rise of its own strobe. A strobe held high, including one held high through reset, does not capture again. Changes of `oe_n`, `dir` and the selects leave stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes and data are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | Word arriving on the A bus |
| b_in | input | 16 | Word arriving on the B bus |
| oe_n | input | 2 | Per-group active-low drive enable |
| dir | input | 2 | Per-group direction: 1 drives B, 0 drives A |
| cap_ab | input | 2 | Per-group strobe; a rise stores A into the A-to-B register |
| cap_ba | input | 2 | Per-group strobe; a rise stores B into the B-to-A register |
| sel_ab | input | 2 | Per-group select for `b_out`: 0 live A, 1 stored word |
| sel_ba | input | 2 | Per-group select for `a_out`: 0 live B, 1 stored word |
| a_out | output | 16 | Word presented to the A bus |
| a_oe | output | 16 | Per-bit drive enable of the A bus |
| b_out | output | 16 | Word presented to the B bus |
| b_oe | output | 16 | Per-bit drive enable of the B bus |

## Verification
The main path is exercised with random per-group control words, so the two groups often sit in different modes at the same time. This separates per-group decoding from any wrongly shared control. The random strobes rise, fall and stay high for several cycles, which tells an edge-triggered capture apart from a level-sensitive one. Directed patterns cover three cases: a strobe held high through reset, a capture made while the outputs are isolated and read back later through the stored select, and a capture in one group while the other group's stored word is watched for disturbance. A run of enable, direction and select changes with the strobes quiet shows that control activity alone cannot alter stored data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which side of a lane group is being driven.
   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_TO_A = 2'b01,
      DRV_TO_B = 2'b10
   } drive_e;

   function automatic drive_e decode_drive(input logic oe_n, input logic dir);
      if (oe_n)
         return DRV_NONE;
      else if (dir)
         return DRV_TO_B;
      else
         return DRV_TO_A;
   endfunction

endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("xcvr_cap_reg: W must be at least 1");
      end
   endgenerate

   logic         cap_q;
   logic         cap_rise;
   logic [W-1:0] hold_q;

   assign cap_rise = cap_i & ~cap_q;

   // During reset the strobe history follows the pin, so a strobe that is
   // already high when reset ends is not taken as a fresh rise.
   always_ff @(posedge clk) begin
      cap_q <= cap_i;
      if (!rst_n)
         hold_q <= '0;
      else if (cap_rise)
         hold_q <= d_i;
   end

   assign q_o = hold_q;

   AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_i) |=> (q_o == $past(d_i)));   // R2

   AST_HOLD_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(cap_i) |=> $stable(q_o));         // R9

endmodule

// File: rtl/xcvr_sel_mux.sv
module xcvr_sel_mux #(
   parameter int W = 8
) (
   input  logic         sel_i,
   input  logic [W-1:0] live_i,
   input  logic [W-1:0] held_i,
   output logic [W-1:0] y_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("xcvr_sel_mux: W must be at least 1");
      end
   endgenerate

   // Single AND-OR level per bit, select fanned out directly: no decoded
   // intermediate state exists between the stored and live sources.
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         assign y_o[i] = (live_i[i] & ~sel_i) | (held_i[i] & sel_i);
      end
   endgenerate

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl #(
   parameter int W = 8
) (
   input  logic         oe_n_i,
   input  logic         dir_i,
   output logic [W-1:0] a_oe_o,
   output logic [W-1:0] b_oe_o
);

   import xcvr_pkg::*;

   generate
      if (W < 1) begin : g_bad_w
         $error("xcvr_drive_ctl: W must be at least 1");
      end
   endgenerate

   drive_e mode;

   always_comb begin
      mode   = decode_drive(oe_n_i, dir_i);
      a_oe_o = '0;
      b_oe_o = '0;
      unique case (mode)
         DRV_TO_A: a_oe_o = '1;
         DRV_TO_B: b_oe_o = '1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int LANE_W  = 8,
   parameter int NUM_GRP = 2,
   localparam int BUS_W  = LANE_W * NUM_GRP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BUS_W-1:0]   a_in,
   input  logic [BUS_W-1:0]   b_in,
   input  logic [NUM_GRP-1:0] oe_n,
   input  logic [NUM_GRP-1:0] dir,
   input  logic [NUM_GRP-1:0] cap_ab,
   input  logic [NUM_GRP-1:0] cap_ba,
   input  logic [NUM_GRP-1:0] sel_ab,
   input  logic [NUM_GRP-1:0] sel_ba,
   output logic [BUS_W-1:0]   a_out,
   output logic [BUS_W-1:0]   a_oe,
   output logic [BUS_W-1:0]   b_out,
   output logic [BUS_W-1:0]   b_oe
);

   generate
      if (LANE_W < 1) begin : g_bad_lane
         $error("regbus_xcvr: LANE_W must be at least 1");
      end
      if (NUM_GRP < 1) begin : g_bad_grp
         $error("regbus_xcvr: NUM_GRP must be at least 1");
      end
   endgenerate

   logic [BUS_W-1:0] q_ab;
   logic [BUS_W-1:0] q_ba;

   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_grp
         localparam int LO = g * LANE_W;

         xcvr_cap_reg #(.W(LANE_W)) u_reg_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (cap_ab[g]),
            .d_i   (a_in[LO +: LANE_W]),
            .q_o   (q_ab[LO +: LANE_W])
         );

         xcvr_cap_reg #(.W(LANE_W)) u_reg_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (cap_ba[g]),
            .d_i   (b_in[LO +: LANE_W]),
            .q_o   (q_ba[LO +: LANE_W])
         );

         xcvr_sel_mux #(.W(LANE_W)) u_mux_b (
            .sel_i  (sel_ab[g]),
            .live_i (a_in[LO +: LANE_W]),
            .held_i (q_ab[LO +: LANE_W]),
            .y_o    (b_out[LO +: LANE_W])
         );

         xcvr_sel_mux #(.W(LANE_W)) u_mux_a (
            .sel_i  (sel_ba[g]),
            .live_i (b_in[LO +: LANE_W]),
            .held_i (q_ba[LO +: LANE_W]),
            .y_o    (a_out[LO +: LANE_W])
         );

         xcvr_drive_ctl #(.W(LANE_W)) u_drv (
            .oe_n_i (oe_n[g]),
            .dir_i  (dir[g]),
            .a_oe_o (a_oe[LO +: LANE_W]),
            .b_oe_o (b_oe[LO +: LANE_W])
         );

         AST_ONE_SIDE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            !((|a_oe[LO +: LANE_W]) && (|b_oe[LO +: LANE_W])));              // R7

         AST_ISOLATED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[g] |-> (a_oe[LO +: LANE_W] == '0 && b_oe[LO +: LANE_W] == '0)); // R6

         AST_DIR_DRIVES_B: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && dir[g]) |-> (&b_oe[LO +: LANE_W]));                 // R5

         AST_DIR_DRIVES_A: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && !dir[g]) |-> (&a_oe[LO +: LANE_W]));                // R5

         AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_ab[g] |-> (b_out[LO +: LANE_W] == a_in[LO +: LANE_W]));     // R4

         AST_STORED_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
            sel_ba[g] |-> (a_out[LO +: LANE_W] == q_ba[LO +: LANE_W]));      // R4
      end
   endgenerate

endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;

   localparam int LANE_W  = 8;
   localparam int NUM_GRP = 2;
   localparam int BUS_W   = LANE_W * NUM_GRP;

   logic               clk = 1'b0;
   logic               rst_n;
   logic [BUS_W-1:0]   a_in, b_in;
   logic [NUM_GRP-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
   logic [BUS_W-1:0]   a_out, a_oe, b_out, b_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Bench model of stored words and strobe history.
   logic [BUS_W-1:0]   m_ab = '0, m_ba = '0;
   logic [NUM_GRP-1:0] p_ab = '0, p_ba = '0;

   always #2 clk = ~clk;

   regbus_xcvr #(.LANE_W(LANE_W), .NUM_GRP(NUM_GRP)) u_regbus_xcvr (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab), .cap_ba(cap_ba),
      .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic chk(string tag, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [LANE_W-1:0] sl(logic [BUS_W-1:0] v, int g);
      return v[g*LANE_W +: LANE_W];
   endfunction

   function automatic logic [LANE_W-1:0] exp_b(int g);
      return sel_ab[g] ? sl(m_ab, g) : sl(a_in, g);
   endfunction

   function automatic logic [LANE_W-1:0] exp_a(int g);
      return sel_ba[g] ? sl(m_ba, g) : sl(b_in, g);
   endfunction

   function automatic logic [LANE_W-1:0] exp_boe(int g);
      return (!oe_n[g] && dir[g]) ? '1 : '0;
   endfunction

   function automatic logic [LANE_W-1:0] exp_aoe(int g);
      return (!oe_n[g] && !dir[g]) ? '1 : '0;
   endfunction

   task automatic check_all();
      for (int g = 0; g < NUM_GRP; g++) begin
         chk(sel_ab[g] ? "R2" : "R4", BUS_W'(sl(b_out, g)), BUS_W'(exp_b(g)));
         chk(sel_ba[g] ? "R3" : "R4", BUS_W'(sl(a_out, g)), BUS_W'(exp_a(g)));
         chk(oe_n[g] ? "R6" : "R5", BUS_W'(sl(b_oe, g)), BUS_W'(exp_boe(g)));
         chk(oe_n[g] ? "R6" : "R5", BUS_W'(sl(a_oe, g)), BUS_W'(exp_aoe(g)));
         chk("R7", BUS_W'((|sl(a_oe, g)) && (|sl(b_oe, g))), '0);
      end
   endtask

   task automatic model_upd();
      for (int g = 0; g < NUM_GRP; g++) begin
         if (!rst_n) begin
            m_ab[g*LANE_W +: LANE_W] = '0;
            m_ba[g*LANE_W +: LANE_W] = '0;
         end else begin
            if (cap_ab[g] && !p_ab[g]) m_ab[g*LANE_W +: LANE_W] = sl(a_in, g);
            if (cap_ba[g] && !p_ba[g]) m_ba[g*LANE_W +: LANE_W] = sl(b_in, g);
         end
      end
      p_ab = cap_ab;
      p_ba = cap_ba;
   endtask

   // Inputs are set just after a falling edge; outputs are checked 1 ns later.
   task automatic step(bit do_chk);
      #1;
      if (do_chk) check_all();
      @(posedge clk);
      model_upd();
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h1F2E3D4C));
      rst_n = 1'b0; a_in = '0; b_in = '0;
      oe_n = '1; dir = '0; sel_ab = '1; sel_ba = '1;
      cap_ab = '1; cap_ba = '1;   // strobes held high through reset
      @(negedge clk);
      for (int i = 0; i < 3; i++) step(1'b0);
      rst_n = 1'b1;
      #1;
      chk("R1", b_out, '0);
      chk("R1", a_out, '0);
      chk("R1", a_oe | b_oe, '0);
      a_in = 16'hA55A; b_in = 16'h3CC3;
      for (int i = 0; i < 3; i++) step(1'b1);
      chk("R9", b_out, '0);        // level held high: no capture
      chk("R9", a_out, '0);

      // Isolated capture, read back later through the stored select.
      cap_ab = '0; cap_ba = '0; step(1'b1);
      a_in = 16'h1234; b_in = 16'hBEEF; cap_ab = '1; cap_ba = '1; step(1'b1);
      a_in = 16'h0000; b_in = 16'hFFFF; step(1'b1);
      #1;
      chk("R6", b_out, 16'h1234);
      chk("R6", a_out, 16'hBEEF);

      // Control churn with strobes quiet.
      for (int i = 0; i < 8; i++) begin
         oe_n = 2'($urandom); dir = 2'($urandom);
         sel_ab = 2'($urandom); sel_ba = 2'($urandom);
         a_in = 16'($urandom); b_in = 16'($urandom);
         step(1'b1);
      end
      sel_ab = '1; sel_ba = '1;
      #1;
      chk("R9", b_out, 16'h1234);
      chk("R9", a_out, 16'hBEEF);

      // Capture in group 0 only; group 1 must keep its word.
      cap_ab = '0; cap_ba = '0; step(1'b1);
      a_in = 16'h7788; b_in = 16'h99AA; cap_ab = 2'b01; cap_ba = 2'b01; step(1'b1);
      #1;
      chk("R8", b_out, 16'h1288);
      chk("R8", a_out, 16'hBEAA);

      // Random mixed traffic.
      for (int i = 0; i < 3000; i++) begin
         a_in   = 16'($urandom);
         b_in   = 16'($urandom);
         oe_n   = 2'($urandom);
         dir    = 2'($urandom);
         sel_ab = 2'($urandom);
         sel_ba = 2'($urandom);
         if (($urandom % 3) == 0) cap_ab = 2'($urandom);
         if (($urandom % 3) == 0) cap_ba = 2'($urandom);
         if (($urandom % 500) == 0) rst_n = 1'b0; else rst_n = 1'b1;
         step(rst_n);
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule